// File: doc/BRIEF.md
# RSSI-driven automatic gain controller

This block closes the gain loop of a receiver. It takes a stream of 7-bit signal-strength codes from a flash converter, which reports levels 0 to 79, and steps a five-entry gain ladder. Each ladder entry pairs a front-end amplifier gain code with a channel filter gain code. A code above the high threshold lowers the gain by one entry and a code below the low threshold raises it by one entry. Either step loads a settling hold. The hold must count down, one accepted sample per count, before another comparison can move the ladder. The low and high thresholds are normally set more than 30 codes apart, so that one step cannot push the level across the opposite threshold.

Each accepted sample also produces an output record. The record holds a readback word, made of the sample code and the gain codes in force when the sample arrived, and a signed input-power estimate in half-dB units. The estimate adds a gain correction, derived from those gain codes, to the code and then offsets the sum to -110 dBm. Either gain path can be placed in manual mode. A manual path takes its code straight from a configuration pin, and the ladder freezes while either path is manual.

Samples arrive on a valid/ready input and records leave on a valid/ready output through a single register. The input is ready whenever that register is empty or is being emptied in the same cycle. While a record waits with out_ready low, the input stalls. No sample is dropped and no record is overwritten.

Top module: `rssi_agc`

## Requirements
- R1: After reset the ladder sits at entry 0 (highest gain, lna_sel=2'b10, filt_sel=2'b10), the hold count is zero and out_valid is 0.
- R2: An accepted sample with code > cfg_hi_thr while the hold is zero moves the ladder one entry toward lower gain. The new gain codes appear on lna_sel/filt_sel in the cycle after the accepting edge.
- R3: An accepted sample with code < cfg_lo_thr while the hold is zero moves the ladder one entry toward higher gain.
- R4: The ladder saturates. A high code at entry 4 or a low code at entry 0 leaves the entry unchanged and does not load the hold.
- R5: Each step loads the hold with cfg_delay. Each later accepted sample decrements a nonzero hold and cannot step the ladder, so the sample that is number cfg_delay+1 after a step is the first that can act. A cfg_delay of 0 gives no hold.
- R6: Ladder entries 0 to 4 drive (lna_sel, filt_sel) = (10,10), (01,10), (01,01), (01,00), (00,00).
- R7: With cfg_lna_auto=0, lna_sel equals cfg_lna_man. With cfg_filt_auto=0, filt_sel equals cfg_filt_man. While either path is manual the ladder entry and the hold do not change.
- R8: out_word = {lna[10:9], filt[8:7], code[6:0]} carries the gain codes that were on the outputs when the sample was accepted.
- R9: out_pwr = -220 + code + L + F, with L = 0/11/30 for lna code 10/01/00 and F = 0/19/38 for filter code 10/01/00. Code 11 counts as 10.
- R10: While out_valid=1 and out_ready=0, out_word and out_pwr hold, rssi_ready is 0 and no sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rssi_valid | input | 1 | Sample present |
| rssi_ready | output | 1 | Sample accepted this cycle when valid |
| rssi_code | input | 7 | Signal-strength code, 0 to 79 |
| cfg_lo_thr | input | 7 | Low threshold |
| cfg_hi_thr | input | 7 | High threshold |
| cfg_delay | input | 8 | Settling hold, in accepted samples |
| cfg_lna_auto | input | 1 | 1: amplifier gain follows the ladder |
| cfg_filt_auto | input | 1 | 1: filter gain follows the ladder |
| cfg_lna_man | input | 2 | Manual amplifier gain code |
| cfg_filt_man | input | 2 | Manual filter gain code |
| lna_sel | output | 2 | Amplifier gain code in force |
| filt_sel | output | 2 | Filter gain code in force |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Downstream takes the record |
| out_word | output | 11 | Readback word |
| out_pwr | output | 9 | Signed input power in half-dB |

## Verification
A wrong ladder entry shows on lna_sel/filt_sel one cycle after the accepting edge. It also shows in the next record's gain bits and power, so the bench compares both against a model after every accepted sample. A hold count that is off by one lets a step through a sample early, or blocks one a sample late, and the first such sample after a step exposes it. The back-pressure corner shows at once as a changed record or a raised rssi_ready while the output is stalled.

// File: rtl/rssi_agc_pkg.sv
package rssi_agc_pkg;
  typedef logic [1:0] gsel_t;

  localparam gsel_t G_HI  = 2'b10;
  localparam gsel_t G_MID = 2'b01;
  localparam gsel_t G_LO  = 2'b00;

  function automatic gsel_t ladder_lna(input logic [2:0] idx);
    case (idx)
      3'd0:    return G_HI;
      3'd4:    return G_LO;
      default: return G_MID;
    endcase
  endfunction

  function automatic gsel_t ladder_filt(input logic [2:0] idx);
    case (idx)
      3'd0, 3'd1: return G_HI;
      3'd2:       return G_MID;
      default:    return G_LO;
    endcase
  endfunction

  function automatic logic [6:0] lna_corr(input gsel_t g);
    case (g)
      G_MID:   return 7'd11;
      G_LO:    return 7'd30;
      default: return 7'd0;
    endcase
  endfunction

  function automatic logic [6:0] filt_corr(input gsel_t g);
    case (g)
      G_MID:   return 7'd19;
      G_LO:    return 7'd38;
      default: return 7'd0;
    endcase
  endfunction
endpackage

// File: rtl/agc_ladder.sv
module agc_ladder #(
  parameter int CODE_W = 7,
  parameter int DLY_W  = 8,
  parameter int NSTEPS = 5,
  localparam int STEP_W = $clog2(NSTEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] lo_thr,
  input  logic [CODE_W-1:0] hi_thr,
  input  logic [DLY_W-1:0]  dly,
  output logic [STEP_W-1:0] step,
  output logic [DLY_W-1:0]  hold
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NSTEPS - 1);

  logic go_down, go_up;
  assign go_down = (code > hi_thr) && (step != LAST);
  assign go_up   = (code < lo_thr) && (step != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0;
      hold <= '0;
    end else if (acc && run) begin
      if (hold != '0) begin
        hold <= hold - 1'b1;
      end else if (go_down) begin
        step <= step + 1'b1;
        hold <= dly;
      end else if (go_up) begin
        step <= step - 1'b1;
        hold <= dly;
      end
    end
  end
endmodule

// File: rtl/agc_gain_map.sv
module agc_gain_map
  import rssi_agc_pkg::*;
#(
  parameter int STEP_W = 3,
  parameter int CORR_W = 7
) (
  input  logic [STEP_W-1:0] step,
  input  logic              lna_auto,
  input  logic              filt_auto,
  input  gsel_t             lna_man,
  input  gsel_t             filt_man,
  output gsel_t             lna,
  output gsel_t             filt,
  output logic [CORR_W-1:0] corr
);
  logic [2:0] idx;
  assign idx  = 3'(step);
  assign lna  = lna_auto  ? ladder_lna(idx)  : lna_man;
  assign filt = filt_auto ? ladder_filt(idx) : filt_man;
  assign corr = CORR_W'(lna_corr(lna)) + CORR_W'(filt_corr(filt));
endmodule

// File: rtl/agc_out_stage.sv
module agc_out_stage #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/rssi_agc.sv
module rssi_agc
  import rssi_agc_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int DLY_W  = 8,
  parameter int NSTEPS = 5,
  localparam int STEP_W = $clog2(NSTEPS),
  localparam int WORD_W = CODE_W + 4,
  localparam int PWR_W  = CODE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rssi_valid,
  output logic              rssi_ready,
  input  logic [CODE_W-1:0] rssi_code,
  input  logic [CODE_W-1:0] cfg_lo_thr,
  input  logic [CODE_W-1:0] cfg_hi_thr,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic              cfg_lna_auto,
  input  logic              cfg_filt_auto,
  input  logic [1:0]        cfg_lna_man,
  input  logic [1:0]        cfg_filt_man,
  output logic [1:0]        lna_sel,
  output logic [1:0]        filt_sel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic [PWR_W-1:0]  out_pwr
);
  localparam int REC_W = PWR_W + WORD_W;

  logic              acc;
  logic [STEP_W-1:0] step;
  logic [DLY_W-1:0]  hold;
  logic [CODE_W-1:0] corr;
  logic [PWR_W-1:0]  pwr;
  logic [REC_W-1:0]  rec_in, rec_out;

  assign acc = rssi_valid && rssi_ready;

  agc_ladder #(.CODE_W(CODE_W), .DLY_W(DLY_W), .NSTEPS(NSTEPS)) u_lad (
    .clk(clk), .rst_n(rst_n), .acc(acc), .run(cfg_lna_auto && cfg_filt_auto),
    .code(rssi_code), .lo_thr(cfg_lo_thr), .hi_thr(cfg_hi_thr), .dly(cfg_delay),
    .step(step), .hold(hold)
  );

  agc_gain_map #(.STEP_W(STEP_W), .CORR_W(CODE_W)) u_map (
    .step(step), .lna_auto(cfg_lna_auto), .filt_auto(cfg_filt_auto),
    .lna_man(cfg_lna_man), .filt_man(cfg_filt_man),
    .lna(lna_sel), .filt(filt_sel), .corr(corr)
  );

  assign pwr    = PWR_W'(rssi_code) + PWR_W'(corr) - PWR_W'(220);
  assign rec_in = {pwr, lna_sel, filt_sel, rssi_code};

  agc_out_stage #(.W(REC_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(rssi_valid), .in_ready(rssi_ready),
    .in_data(rec_in), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(rec_out)
  );

  assign out_pwr  = rec_out[REC_W-1 -: PWR_W];
  assign out_word = rec_out[WORD_W-1:0];
endmodule

// File: rtl/agc_checker.sv
module agc_checker #(
  parameter int STEP_W = 3,
  parameter int DLY_W  = 8,
  parameter int NSTEPS = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rssi_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [10:0]       out_word,
  input logic [8:0]        out_pwr,
  input logic [STEP_W-1:0] step,
  input logic [DLY_W-1:0]  hold,
  input logic [1:0]        lna_sel,
  input logic [1:0]        filt_sel,
  input logic              lna_auto,
  input logic              filt_auto
);
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step < STEP_W'(NSTEPS)); // R4
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step == $past(step)) || (step == $past(step) + 1'b1) || ($past(step) == step + 1'b1)); // R2
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold != '0) |=> $stable(step)); // R5
  AST_MANUAL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lna_auto && filt_auto) |=> $stable(step)); // R7
  AST_LADDER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (lna_auto && filt_auto) |-> ({lna_sel, filt_sel} inside {4'b1010, 4'b0110, 4'b0101, 4'b0100, 4'b0000})); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_pwr))); // R10
  AST_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !rssi_ready); // R10
endmodule

bind rssi_agc agc_checker #(.STEP_W(STEP_W), .DLY_W(DLY_W), .NSTEPS(NSTEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rssi_ready(rssi_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_word(out_word), .out_pwr(out_pwr),
  .step(u_lad.step), .hold(u_lad.hold), .lna_sel(lna_sel), .filt_sel(filt_sel),
  .lna_auto(cfg_lna_auto), .filt_auto(cfg_filt_auto)
);

// File: tb/tb_rssi_agc.sv
module tb_rssi_agc;
  logic       clk = 0, rst_n = 0;
  logic       rssi_valid = 0, out_ready = 1;
  logic       rssi_ready, out_valid;
  logic [6:0] rssi_code = 0, lo_thr = 30, hi_thr = 70;
  logic [7:0] dly = 3;
  logic       lna_auto = 1, filt_auto = 1;
  logic [1:0] lna_man = 0, filt_man = 0, lna_sel, filt_sel;
  logic [10:0] out_word;
  logic [8:0]  out_pwr;

  int total = 0, bad = 0;
  int m_step = 0, m_hold = 0;
  int unsigned seed = 32'h5eed_1234;

  always #5 clk = ~clk;

  rssi_agc dut (
    .clk(clk), .rst_n(rst_n), .rssi_valid(rssi_valid), .rssi_ready(rssi_ready),
    .rssi_code(rssi_code), .cfg_lo_thr(lo_thr), .cfg_hi_thr(hi_thr), .cfg_delay(dly),
    .cfg_lna_auto(lna_auto), .cfg_filt_auto(filt_auto), .cfg_lna_man(lna_man),
    .cfg_filt_man(filt_man), .lna_sel(lna_sel), .filt_sel(filt_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_pwr(out_pwr)
  );

  function automatic logic [1:0] e_lna(int s);
    return (s == 0) ? 2'b10 : (s == 4) ? 2'b00 : 2'b01;
  endfunction
  function automatic logic [1:0] e_filt(int s);
    return (s <= 1) ? 2'b10 : (s == 2) ? 2'b01 : 2'b00;
  endfunction
  function automatic int c_lna(logic [1:0] g);
    return (g == 2'b01) ? 11 : (g == 2'b00) ? 30 : 0;
  endfunction
  function automatic int c_filt(logic [1:0] g);
    return (g == 2'b01) ? 19 : (g == 2'b00) ? 38 : 0;
  endfunction
  function automatic logic [1:0] cur_lna();
    return lna_auto ? e_lna(m_step) : lna_man;
  endfunction
  function automatic logic [1:0] cur_filt();
    return filt_auto ? e_filt(m_step) : filt_man;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step(int code);
    if (!(lna_auto && filt_auto)) return;
    if (m_hold != 0) m_hold--;
    else if (code > hi_thr && m_step < 4) begin m_step++; m_hold = dly; end
    else if (code < lo_thr && m_step > 0) begin m_step--; m_hold = dly; end
  endtask

  // Offers one sample until accepted; out_ready randomised when rnd is set.
  task automatic send(int code, bit rnd);
    bit rdy;
    logic [1:0] gl, gf;
    do begin
      @(negedge clk);
      if (rnd) out_ready = ($urandom(seed) % 4) != 0;
      rssi_valid = 1; rssi_code = 7'(code);
      #1 rdy = rssi_ready;
      gl = cur_lna(); gf = cur_filt();
      @(posedge clk); #1;
    end while (!rdy);
    model_step(code);
    check("R8 word", int'(out_word), int'({gl, gf, 7'(code)}));
    check("R9 pwr", int'($signed(out_pwr)), -220 + code + c_lna(gl) + c_filt(gf));
    check("R6 gains", int'({lna_sel, filt_sel}), int'({cur_lna(), cur_filt()}));
    @(negedge clk); rssi_valid = 0; out_ready = 1;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid", out_valid, 0);
    check("R1 gains", int'({lna_sel, filt_sel}), int'(4'b1010));
    @(negedge clk); rst_n = 1;

    // R2 with R5 hold of 3: high codes walk down every 4th sample, R4 saturates.
    for (int i = 0; i < 20; i++) send(75, 0);
    check("R4 bottom", int'({lna_sel, filt_sel}), int'(4'b0000));
    // R3 back up with low codes
    for (int i = 0; i < 8; i++) send(10, 0);
    check("R3 up", int'({lna_sel, filt_sel}), int'(4'b0101));
    for (int i = 0; i < 12; i++) send(5, 0);
    check("R4 top", int'({lna_sel, filt_sel}), int'(4'b1010));

    // R5 zero hold: each high sample steps at once
    dly = 0;
    send(79, 0);
    check("R5 nohold", int'({lna_sel, filt_sel}), int'(4'b0110));
    send(79, 0);
    check("R5 nohold2", int'({lna_sel, filt_sel}), int'(4'b0101));
    send(50, 0);
    check("R5 mid", int'({lna_sel, filt_sel}), int'(4'b0101));

    // R7 manual: lna forced, ladder frozen
    lna_auto = 0; lna_man = 2'b11;
    for (int i = 0; i < 4; i++) send(79, 0);
    check("R7 lna man", int'(lna_sel), 3);
    check("R7 frozen", int'(filt_sel), 1);
    filt_auto = 0; filt_man = 2'b00;
    send(0, 0);
    check("R7 filt man", int'(filt_sel), 0);
    lna_auto = 1; filt_auto = 1;

    // R10 back-pressure
    @(negedge clk);
    out_ready = 0; rssi_valid = 1; rssi_code = 7'd40;
    @(posedge clk); #1;
    model_step(40);
    check("R10 valid", out_valid, 1);
    check("R10 ready", rssi_ready, 0);
    @(negedge clk); rssi_code = 7'd79;
    repeat (3) @(posedge clk);
    #1;
    check("R10 held", int'(out_word[6:0]), 40);
    check("R10 no step", int'({lna_sel, filt_sel}), int'(4'b0101));
    @(negedge clk); rssi_valid = 0; out_ready = 1;
    @(negedge clk);

    // random phase
    for (int ph = 0; ph < 6; ph++) begin
      dly = 8'($urandom(seed) % 6);
      for (int i = 0; i < 60; i++) begin
        int sel = $urandom(seed) % 3;
        int c = (sel == 0) ? 71 + $urandom(seed) % 9 :
                (sel == 1) ? $urandom(seed) % 30 : 30 + $urandom(seed) % 41;
        send(c, 1);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule